// File: doc/BRIEF.md
# Single-Channel Word DMA Engine

This block is one DMA channel that copies 32-bit words between a word-addressed main memory port and a peripheral stream port. Software places a byte start address, a word count, a block count, a direction, a step sense and a mode on the configuration inputs, then pulses `go`. The engine latches the configuration and walks the addresses. In RAM-to-device transfers it reads memory and offers each word on a valid/ready transmit port. In device-to-RAM transfers it accepts words on a valid/ready receive port and writes them to memory.

Two modes exist. Single-burst mode moves the programmed word count once. Block mode moves that many words per block, for up to the programmed number of blocks. The first block always runs. Each later block runs only if the peripheral's request input is still high when the previous block ends.

The engine also models the timing of the memory. A burst that climbs upward and lies wholly inside the fast 2 MiB region costs one cycle per word, plus one row-open cycle at the start of every group of 16 words. Any other burst pays a fixed penalty on every word. A one-cycle completion pulse ends every run.

Top module: `dmae_channel`

## Requirements
- R1: The first memory word address is the configured byte address with its two low bits discarded, limited to the 24-bit address space; `ram_addr` carries the word index (byte address divided by 4).
- R2: With `cfg_reverse` low, each later word address is one word above the previous one. With it high, each is one word below. The word index wraps modulo 2^22, so a descent below index 0 continues at index 0x3FFFFF.
- R3: A `go` pulse while the engine is idle raises `trig_pending`. On the next clock edge `trig_pending` falls and `busy` rises together. A `go` pulse while busy has no effect.
- R4: In single-burst mode (`cfg_block_mode` = 0) exactly `cfg_words` words move. When `cfg_to_dev` = 1, memory is read (`ram_we` = 0) and the read words appear on `tx_data` in address order. When `cfg_to_dev` = 0, received words are written (`ram_we` = 1) in arrival order.
- R5: In block mode (`cfg_block_mode` = 1) each block moves `cfg_words` words, and at most `cfg_blocks` blocks run. The first block runs regardless of `dev_req`. A later block starts only if `dev_req` is high in the cycle the previous block's last word completes; otherwise the run ends.
- R6: In block mode each block begins at the address directly after the last word of the previous block, in the step direction, so that consecutive blocks are contiguous.
- R7: A burst counts as fast when it steps upward and its word index plus its length is at most 0x80000 (the 2 MiB region). A fast burst spends exactly one stall cycle before words 0, 16, 32, … of the burst, so it costs n + ceil(n/16) memory cycles. Each block is its own burst.
- R8: A burst that is not fast, because it steps downward or extends past 2 MiB, spends SLOW_WAIT stall cycles (default 6) before every word.
- R9: A `cfg_words` of 0, or a `cfg_blocks` of 0 in block mode, makes no memory or peripheral access but still completes.
- R10: `done` is high for exactly one cycle at the end of every run, and the engine is idle on the following cycle.
- R11: `tx_data` holds steady while `tx_valid` is high and `tx_ready` low. At most one of `ram_en`, `tx_valid`, `rx_ready` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 24 | Start byte address |
| cfg_words | input | 16 | Words per burst (per block in block mode) |
| cfg_blocks | input | 16 | Block count, block mode only |
| cfg_block_mode | input | 1 | 1 = request-gated block mode, 0 = single burst |
| cfg_to_dev | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| cfg_reverse | input | 1 | 1 = step addresses downward |
| go | input | 1 | Start pulse |
| dev_req | input | 1 | Peripheral request, gates further blocks |
| trig_pending | output | 1 | Start bit, cleared as the run begins |
| busy | output | 1 | Run in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| ram_en | output | 1 | Memory access strobe |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | 22 | Memory word index |
| ram_wdata | output | 32 | Memory write data |
| ram_rdata | input | 32 | Memory read data, valid in the strobe cycle |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_ready | input | 1 | Peripheral accepts transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Engine accepts receive word |

## Verification
The address-step property latches the step sense when the start bit is consumed. It therefore assumes that the configuration inputs stay constant for the whole run, and it assumes that memory returns read data in the same cycle as the strobe. The stimulus changes configuration only while the engine is idle, drives a combinational memory model, and throttles `tx_ready` and `rx_valid` on a fixed repeating pattern. That throttling makes the transmit hold property active without breaking the peripheral side of the handshake. `dev_req` is held constant across each run, so the gating of later blocks depends only on its level at the end of each block.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_MEM,
      ST_SEND,
      ST_RECV,
      ST_DONE
   } dmae_state_e;
endpackage

// File: rtl/dmae_addr_gen.sv
module dmae_addr_gen #(
   parameter int AW        = 22,
   parameter int CNT_W     = 16,
   parameter int RAM_WORDS = 32'h80000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [AW-1:0]    base_wa,
   input  logic             base_rev,
   input  logic [CNT_W-1:0] base_len,
   input  logic             run_rev,
   input  logic [CNT_W-1:0] run_len,
   output logic [AW-1:0]    wa_q,
   output logic             fast_base,
   output logic             fast_next
);
   localparam int EW = AW + CNT_W + 1;

   logic [AW-1:0] wa_nxt;

   assign wa_nxt = run_rev ? wa_q - AW'(1) : wa_q + AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    wa_q <= '0;
      else if (load) wa_q <= base_wa;
      else if (step) wa_q <= wa_nxt;
   end

   generate
      if (RAM_WORDS == 0) begin : g_no_fast
         assign fast_base = 1'b0;
         assign fast_next = 1'b0;
      end else begin : g_fast
         logic [EW-1:0] end_base, end_next;
         assign end_base  = EW'(base_wa) + EW'(base_len);
         assign end_next  = EW'(wa_nxt) + EW'(run_len);
         assign fast_base = !base_rev && (end_base <= EW'(RAM_WORDS));
         assign fast_next = !run_rev && (end_next <= EW'(RAM_WORDS));
      end
   endgenerate
endmodule

// File: rtl/dmae_cost_timer.sv
module dmae_cost_timer #(
   parameter int SLOW_WAIT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_req,
   input  logic fast,
   input  logic row_start,
   output logic skip,
   output logic wait_last
);
   localparam int MAXV = (SLOW_WAIT > 1) ? SLOW_WAIT : 1;
   localparam int CW   = $clog2(MAXV + 1);

   logic [CW-1:0] load_val, cnt_q;

   generate
      if (SLOW_WAIT == 0) begin : g_free_slow
         assign load_val = (fast && row_start) ? CW'(1) : '0;
      end else begin : g_paid_slow
         assign load_val = fast ? (row_start ? CW'(1) : '0) : CW'(SLOW_WAIT);
      end
   endgenerate

   assign skip      = (load_val == '0);
   assign wait_last = (cnt_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_req && !skip) cnt_q <= load_val;
      else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
   end
endmodule

// File: rtl/dmae_channel.sv
module dmae_channel
   import dmae_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int RAM_BYTES = 32'h200000,
   parameter int ROW_WORDS = 16,
   parameter int SLOW_WAIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_words,
   input  logic [CNT_W-1:0]  cfg_blocks,
   input  logic              cfg_block_mode,
   input  logic              cfg_to_dev,
   input  logic              cfg_reverse,
   input  logic              go,
   input  logic              dev_req,
   output logic              trig_pending,
   output logic              busy,
   output logic              done,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-3:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready
);
   localparam int AW        = ADDR_W - 2;
   localparam int ROW_W     = $clog2(ROW_WORDS);
   localparam int RAM_WORDS = RAM_BYTES / 4;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dmae_channel: ADDR_W must be at least 4");
      end
      if (ROW_WORDS < 2 || (ROW_WORDS & (ROW_WORDS - 1)) != 0) begin : g_bad_row
         $error("dmae_channel: ROW_WORDS must be a power of two >= 2");
      end
      if (RAM_BYTES % 4 != 0) begin : g_bad_ram
         $error("dmae_channel: RAM_BYTES must be word aligned");
      end
   endgenerate

   dmae_state_e       state_q, state_d;
   logic              trig_q, mode_q, to_dev_q, rev_q, fast_q;
   logic [CNT_W-1:0]  bs_q, word_left_q, blk_left_q;
   logic [ROW_W-1:0]  grp_q, grp_inc;
   logic [DATA_W-1:0] hold_q;
   logic [AW-1:0]     wa_q;
   logic              fast_base, fast_next;
   logic              tx_hs, rx_hs, word_done, last_word, more_blk;
   logic              start_go, zero_cfg, new_burst, dir, enter_acc;
   logic              tmr_fast, tmr_row0, acc_skip, wait_last;
   logic              unused_lo;

   assign unused_lo = ^cfg_base[1:0];

   dmae_addr_gen #(.AW(AW), .CNT_W(CNT_W), .RAM_WORDS(RAM_WORDS)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_go),
      .step      (word_done),
      .base_wa   (cfg_base[ADDR_W-1:2]),
      .base_rev  (cfg_reverse),
      .base_len  (cfg_words),
      .run_rev   (rev_q),
      .run_len   (bs_q),
      .wa_q      (wa_q),
      .fast_base (fast_base),
      .fast_next (fast_next)
   );

   dmae_cost_timer #(.SLOW_WAIT(SLOW_WAIT)) u_cost (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (enter_acc),
      .fast      (tmr_fast),
      .row_start (tmr_row0),
      .skip      (acc_skip),
      .wait_last (wait_last)
   );

   always_comb begin
      tx_hs     = (state_q == ST_SEND) && tx_ready;
      rx_hs     = (state_q == ST_RECV) && rx_valid;
      word_done = to_dev_q ? tx_hs : (state_q == ST_MEM);
      last_word = (word_left_q == CNT_W'(1));
      more_blk  = mode_q && (blk_left_q > CNT_W'(1)) && dev_req;
      start_go  = (state_q == ST_IDLE) && trig_q;
      zero_cfg  = (cfg_words == '0) || (cfg_block_mode && (cfg_blocks == '0));
      new_burst = (start_go && !zero_cfg) || (word_done && last_word && more_blk);
      dir       = start_go ? cfg_to_dev : to_dev_q;
      enter_acc = (new_burst && dir) || (word_done && !last_word && to_dev_q) || rx_hs;
      grp_inc   = grp_q + ROW_W'(1);
      tmr_fast  = new_burst ? (start_go ? fast_base : fast_next) : fast_q;
      tmr_row0  = new_burst ? 1'b1 : (rx_hs ? (grp_q == '0) : (grp_inc == '0));

      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start_go) begin
            if (zero_cfg)       state_d = ST_DONE;
            else if (enter_acc) state_d = acc_skip ? ST_MEM : ST_WAIT;
            else                state_d = ST_RECV;
         end
         ST_WAIT: if (wait_last) state_d = ST_MEM;
         ST_MEM: begin
            if (to_dev_q)                    state_d = ST_SEND;
            else if (last_word && !more_blk) state_d = ST_DONE;
            else                             state_d = ST_RECV;
         end
         ST_SEND: if (tx_ready) begin
            if (enter_acc) state_d = acc_skip ? ST_MEM : ST_WAIT;
            else           state_d = ST_DONE;
         end
         ST_RECV: if (rx_valid) state_d = acc_skip ? ST_MEM : ST_WAIT;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         trig_q      <= 1'b0;
         mode_q      <= 1'b0;
         to_dev_q    <= 1'b0;
         rev_q       <= 1'b0;
         fast_q      <= 1'b0;
         bs_q        <= '0;
         word_left_q <= '0;
         blk_left_q  <= '0;
         grp_q       <= '0;
         hold_q      <= '0;
      end else begin
         state_q <= state_d;
         if (start_go)                         trig_q <= 1'b0;
         else if (go && state_q == ST_IDLE)    trig_q <= 1'b1;
         if (start_go) begin
            mode_q     <= cfg_block_mode;
            to_dev_q   <= cfg_to_dev;
            rev_q      <= cfg_reverse;
            bs_q       <= cfg_words;
            blk_left_q <= cfg_block_mode ? cfg_blocks : CNT_W'(1);
         end else if (word_done && last_word && more_blk) begin
            blk_left_q <= blk_left_q - CNT_W'(1);
         end
         if (new_burst) begin
            word_left_q <= start_go ? cfg_words : bs_q;
            grp_q       <= '0;
            fast_q      <= tmr_fast;
         end else if (word_done) begin
            word_left_q <= word_left_q - CNT_W'(1);
            grp_q       <= grp_inc;
         end
         if (state_q == ST_MEM && to_dev_q) hold_q <= ram_rdata;
         else if (rx_hs)                    hold_q <= rx_data;
      end
   end

   assign trig_pending = trig_q;
   assign busy         = (state_q != ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign ram_en       = (state_q == ST_MEM);
   assign ram_we       = ram_en && !to_dev_q;
   assign ram_addr     = wa_q;
   assign ram_wdata    = hold_q;
   assign tx_valid     = (state_q == ST_SEND);
   assign tx_data      = hold_q;
   assign rx_ready     = (state_q == ST_RECV);
endmodule

// File: rtl/dmae_channel_chk.sv
module dmae_channel_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_reverse,
   input logic              trig_pending,
   input logic              busy,
   input logic              done,
   input logic              ram_en,
   input logic [ADDR_W-3:0] ram_addr,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_ready,
   input logic              rx_ready
);
   localparam int AW = ADDR_W - 2;

   logic          seen_q, rev_seen_q;
   logic [AW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         rev_seen_q <= 1'b0;
         last_q     <= '0;
      end else begin
         if (trig_pending && !busy) rev_seen_q <= cfg_reverse;
         if (!busy) seen_q <= 1'b0;
         else if (ram_en) begin
            seen_q <= 1'b1;
            last_q <= ram_addr;
         end
      end
   end

   AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pending && !busy |=> busy && !trig_pending); // R3

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en && seen_q |-> ram_addr == (rev_seen_q ? last_q - AW'(1) : last_q + AW'(1))); // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R10

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11

   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_en, tx_valid, rx_ready, done})); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ram_en && !tx_valid && !rx_ready); // R9
endmodule

bind dmae_channel dmae_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_reverse  (cfg_reverse),
   .trig_pending (trig_pending),
   .busy         (busy),
   .done         (done),
   .ram_en       (ram_en),
   .ram_addr     (ram_addr),
   .tx_valid     (tx_valid),
   .tx_data      (tx_data),
   .tx_ready     (tx_ready),
   .rx_ready     (rx_ready)
);

// File: tb/dmae_channel_bench.sv
`timescale 1ns/1ps
module dmae_channel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cfg_base = '0;
   logic [15:0] cfg_words = '0, cfg_blocks = '0;
   logic        cfg_block_mode = 1'b0, cfg_to_dev = 1'b0, cfg_reverse = 1'b0;
   logic        go = 1'b0, dev_req = 1'b0;
   logic        trig_pending, busy, done, ram_en, ram_we, tx_valid, rx_ready;
   logic [21:0] ram_addr;
   logic [31:0] ram_wdata, ram_rdata, tx_data, rx_data;
   logic        tx_ready, rx_valid;
   logic [7:0]  pat = '0;
   int unsigned rx_cnt = 0;

   always #2 clk = ~clk;

   dmae_channel u_dmae_channel (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_words(cfg_words),
      .cfg_blocks(cfg_blocks), .cfg_block_mode(cfg_block_mode), .cfg_to_dev(cfg_to_dev),
      .cfg_reverse(cfg_reverse), .go(go), .dev_req(dev_req), .trig_pending(trig_pending),
      .busy(busy), .done(done), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
   );

   // memory and peripheral models
   assign ram_rdata = {10'h155, ram_addr};
   assign tx_ready  = (pat[1:0] != 2'd0);
   assign rx_valid  = (pat[1:0] != 2'd3);
   assign rx_data   = 32'hC0DE0000 + rx_cnt;
   always @(posedge clk) begin
      pat <= pat + 8'd1;
      if (rx_valid && rx_ready) rx_cnt <= rx_cnt + 1;
   end

   typedef struct packed {
      logic        we;
      logic [21:0] addr;
      logic [31:0] data;
   } mem_item_t;

   mem_item_t   exp_mem[$];
   logic [31:0] exp_tx[$];
   int total = 0, fails = 0, stall_cnt = 0, done_cnt = 0;
   bit finished = 0;

   function automatic void check(bit ok, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endfunction

   // monitor: pops expected items as the design produces them
   always @(negedge clk) if (rst_n) begin
      mem_item_t it;
      logic [31:0] d;
      if (ram_en) begin
         if (exp_mem.size() == 0) check(0, "R4 unexpected memory access", ram_addr, 0);
         else begin
            it = exp_mem.pop_front();
            check(ram_addr == it.addr, "R2 memory word address", ram_addr, it.addr);
            check(ram_we == it.we, "R4 memory write enable", ram_we, it.we);
            if (it.we) check(ram_wdata == it.data, "R4 written data", ram_wdata, it.data);
         end
      end
      if (tx_valid && tx_ready) begin
         if (exp_tx.size() == 0) check(0, "R4 unexpected transmit word", tx_data, 0);
         else begin
            d = exp_tx.pop_front();
            check(tx_data == d, "R4 transmit data", tx_data, d);
         end
      end
      if (busy && !done && !ram_en && !tx_valid && !rx_ready) stall_cnt++;
      if (done) done_cnt++;
   end

   task automatic run(input logic [23:0] base, input int words, input int blocks,
                      input bit bmode, input bit todev, input bit rev, input bit req,
                      input int nblk, input bit go_mid, input string tag);
      int wa, exp_stall, k, t;
      bit fast;
      mem_item_t it;
      wa = int'(base[23:2]);
      exp_stall = 0;
      k = 0;
      for (int b = 0; b < nblk; b++) begin
         fast = !rev && (wa + words <= 32'h80000);
         exp_stall += fast ? (words + 15) / 16 : words * 6;
         for (int i = 0; i < words; i++) begin
            it.we   = !todev;
            it.addr = wa[21:0];
            it.data = todev ? 32'h0 : 32'hC0DE0000 + rx_cnt + k;
            exp_mem.push_back(it);
            if (todev) exp_tx.push_back({10'h155, wa[21:0]});
            k++;
            wa = rev ? ((wa - 1) & 32'h3FFFFF) : ((wa + 1) & 32'h3FFFFF);
         end
      end
      @(negedge clk);
      cfg_base = base; cfg_words = 16'(words); cfg_blocks = 16'(blocks);
      cfg_block_mode = bmode; cfg_to_dev = todev; cfg_reverse = rev; dev_req = req;
      stall_cnt = 0; done_cnt = 0;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      check(trig_pending && !busy, {"R3 start bit set ", tag}, {trig_pending, busy}, 2'b10);
      @(negedge clk);
      check(!trig_pending && busy, {"R3 start bit cleared at begin ", tag}, {trig_pending, busy}, 2'b01);
      if (go_mid) begin
         go = 1'b1;
         @(negedge clk);
         go = 1'b0;
      end
      t = 0;
      while (done_cnt == 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      check(done_cnt == 1, {"R10 single done pulse ", tag}, done_cnt, 1);
      check(!busy && !trig_pending, {"R3 idle after run, no retrigger ", tag}, {busy, trig_pending}, 0);
      check(exp_mem.size() == 0, {"R5 all memory words seen ", tag}, exp_mem.size(), 0);
      check(exp_tx.size() == 0, {"R4 all transmit words seen ", tag}, exp_tx.size(), 0);
      check(stall_cnt == exp_stall, {"R7/R8 memory stall cycles ", tag}, stall_cnt, exp_stall);
      exp_mem.delete();
      exp_tx.delete();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(!busy && !done && !ram_en && !tx_valid && !rx_ready && !trig_pending,
            "R10 reset state quiet", {busy, done, ram_en, tx_valid, rx_ready, trig_pending}, 0);
      rst_n = 1'b1;
      // R1 unaligned base, R7 fast with two row opens, R3 go while busy
      run(24'h000103, 20, 0, 0, 1, 0, 0, 1, 1, "R1 manual fast to device");
      // R4 device to memory, R8 reverse is slow
      run(24'h000400, 5, 0, 0, 0, 1, 0, 1, 0, "R4 manual reverse from device");
      // R8 mirror region beyond 2 MiB
      run(24'h3FFFF8, 4, 0, 0, 1, 0, 0, 1, 0, "R8 beyond fast region");
      // R7 burst ending exactly at 2 MiB is fast; one more word is slow
      run(24'h1FFFF8, 2, 0, 0, 1, 0, 0, 1, 0, "R7 edge fits");
      run(24'h1FFFF8, 3, 0, 0, 1, 0, 0, 1, 0, "R8 edge overflows");
      // R2 downward wrap below index 0
      run(24'h000004, 3, 0, 0, 1, 1, 0, 1, 0, "R2 reverse wrap");
      // R5 R6 block mode with request held
      run(24'h001000, 4, 3, 1, 1, 0, 1, 3, 0, "R6 block to device");
      run(24'h002000, 17, 2, 1, 0, 0, 1, 2, 1, "R5 block from device");
      // R5 request low: only the first block
      run(24'h003000, 4, 3, 1, 1, 0, 0, 1, 0, "R5 request dropped");
      // R9 zero counts
      run(24'h004000, 0, 0, 0, 1, 0, 0, 1, 0, "R9 zero words");
      run(24'h005000, 5, 0, 1, 0, 0, 1, 0, 0, "R9 zero blocks");
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule